// File: doc/BRIEF.md
# Serial Receiver Status Flag Controller

This block holds the receive-side status of an asynchronous serial receiver. A shift register elsewhere reports each finished character with a one-cycle strobe and its data. A bit-rate tick comes with a sample of the receive line. The block keeps a one-character holding register and three flags.

The three flags are full, idle and overrun. Full means a character is waiting. Overrun means a character arrived while the holding register was still occupied. Idle means the line has stayed high for a whole frame time.

A host reads the block through a small read port that selects either a status word or the holding register. A flag clears only through a two-step sequence. The host first reads the status word while the flag is set, and then reads the holding register. A combined error interrupt is raised for idle and for overrun, each under its own enable input.

Idle detection runs as a three-state machine:
- `IDL_WAIT` means disarmed. It moves to `IDL_COUNT` when a character is loaded while the receiver is enabled.
- `IDL_COUNT` counts consecutive high samples. It moves to `IDL_SET` when the count reaches the frame length. It moves back to `IDL_WAIT` when the enable input drops.
- `IDL_SET` means the idle flag is raised. It moves to `IDL_WAIT` when an armed data read clears the flag.

Top module: `rx_status_flags`

## Requirements
- R1: After reset, the status word and `err_irq` are all zero. Status bit 0 is full, bit 1 is idle and bit 2 is overrun. The remaining bits read as zero.
- R2: A `char_done` strobe while full is clear loads `char_data` into the holding register and sets full. The holding register is read with `rd_sel`=1, and the status word with `rd_sel`=0.
- R3: A `char_done` strobe while full is set, and not being cleared in that cycle, sets overrun. The new character is discarded and the holding register keeps its earlier value.
- R4: Once armed, idle sets after consecutive high line samples on `bit_tick`. The count is 10 samples when `long_frame`=0 and 11 samples when `long_frame`=1. One sample fewer leaves idle clear.
- R5: Idle cannot set until a character has been loaded since the receiver was enabled. After idle has been cleared, another loaded character is needed before idle can set again.
- R6: A low line sample on a `bit_tick` restarts the consecutive-high count from zero.
- R7: Full, idle and overrun each clear on a data read (`rd_en`=1, `rd_sel`=1) only when an earlier status read (`rd_en`=1, `rd_sel`=0) returned that flag as set. A data read with no such status read leaves the flags unchanged.
- R8: If overrun sets after the status read, the following data read leaves overrun set. The next complete clear sequence then returns the character that arrived after the lost one.
- R9: `err_irq` is high exactly when (idle and `idle_irq_en`) or (overrun and `ovr_irq_en`).
- R10: Dropping `rx_enable` while idle is not set disarms idle detection and discards the partial count.
- R11: A character strobe in the same cycle as a data read that clears full loads the new character. Full stays set and overrun is not raised.
- R12: Repeated status reads between the status read and the data read do not cancel the arming of a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receiver enable; low disarms idle detection |
| long_frame | input | 1 | 0: 10-bit idle window, 1: 11-bit idle window |
| bit_tick | input | 1 | One strobe per bit time; `rx_line` is sampled on it |
| rx_line | input | 1 | Receive line level |
| char_done | input | 1 | Character finished in the shift register |
| char_data | input | DATA_W | Finished character |
| rd_en | input | 1 | Read access strobe |
| rd_sel | input | 1 | 0: status word, 1: holding register |
| rd_rdata | output | DATA_W | Read data, combinational from `rd_sel` |
| idle_irq_en | input | 1 | Interrupt enable for idle |
| ovr_irq_en | input | 1 | Interrupt enable for overrun |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults: 8-bit characters and a short idle window of 10 bit times. It switches `long_frame` during the run so that both the 10-sample and the 11-sample windows are reached. Directed sequences cover several cases:
- the boundary one sample short of each window;
- a restart caused by a low sample;
- the late-overrun clear order;
- a character landing on a clearing read.

A seeded random phase then mixes reads, ticks, characters and enable drops against a bench model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        IDL_WAIT  = 2'd0,
        IDL_COUNT = 2'd1,
        IDL_SET   = 2'd2
    } idle_state_e;

    localparam int ST_FULL = 0;
    localparam int ST_IDLE = 1;
    localparam int ST_OVR  = 2;
endpackage

// File: rtl/rxf_idle_fsm.sv
module rxf_idle_fsm
    import rxf_pkg::*;
#(
    parameter int IDLE_SHORT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_enable,
    input  logic long_frame,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic char_loaded,
    input  logic idle_clear,
    output logic idle_flag
);
    localparam int IDLE_LONG = IDLE_SHORT + 1;
    localparam int CNT_W     = $clog2(IDLE_LONG + 1);

    idle_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] target;

    assign target = long_frame ? CNT_W'(IDLE_LONG) : CNT_W'(IDLE_SHORT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDL_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IDL_WAIT: begin
                cnt_d = '0;
                if (rx_enable && char_loaded) state_d = IDL_COUNT;
            end
            IDL_COUNT: begin
                if (!rx_enable) begin
                    state_d = IDL_WAIT;
                    cnt_d   = '0;
                end else if (bit_tick) begin
                    if (!rx_line) begin
                        cnt_d = '0;
                    end else if (cnt_q + CNT_W'(1) >= target) begin
                        state_d = IDL_SET;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            IDL_SET: begin
                if (idle_clear) state_d = IDL_WAIT;
            end
            default: state_d = IDL_WAIT;
        endcase
    end

    always_comb begin
        idle_flag = (state_q == IDL_SET);
    end

    // R4: idle only appears right after a high sample on a tick
    assert_idle_on_high_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(bit_tick && rx_line && rx_enable));
    // R5: a disarmed detector cannot raise idle in the next cycle
    assert_idle_needs_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDL_WAIT) |=> (state_q != IDL_SET));
    // R6: a low sample restarts the count
    assert_low_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDL_COUNT && rx_enable && bit_tick && !rx_line) |=> (cnt_q == '0));
    // R7: idle falls only through the clearing read
    assert_idle_clear_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_flag) |-> $past(idle_clear));
    // R10: disable drops arming
    assert_disable_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && state_q != IDL_SET) |=> (state_q == IDL_WAIT));
endmodule

// File: rtl/rxf_flag_ctrl.sv
module rxf_flag_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              status_rd,
    input  logic              data_rd,
    input  logic              idle_flag,
    output logic              full_q,
    output logic              ovr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              char_loaded,
    output logic              idle_clear
);
    logic arm_full, arm_idle, arm_ovr;
    logic clr_full, clr_ovr, ovr_set;

    always_comb begin
        clr_full    = data_rd && arm_full;
        clr_ovr     = data_rd && arm_ovr;
        idle_clear  = data_rd && arm_idle;
        char_loaded = char_done && (!full_q || clr_full);
        ovr_set     = char_done && full_q && !clr_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= 1'b0;
            ovr_q    <= 1'b0;
            data_q   <= '0;
            arm_full <= 1'b0;
            arm_idle <= 1'b0;
            arm_ovr  <= 1'b0;
        end else begin
            full_q <= char_loaded || (full_q && !clr_full);
            ovr_q  <= ovr_set || (ovr_q && !clr_ovr);
            if (char_loaded) data_q <= char_data;
            if (status_rd) begin
                arm_full <= full_q;
                arm_idle <= idle_flag;
                arm_ovr  <= ovr_q;
            end else if (data_rd) begin
                arm_full <= 1'b0;
                arm_idle <= 1'b0;
                arm_ovr  <= 1'b0;
            end
        end
    end

    // R2: a character into an empty register is held and flagged
    assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !full_q) |=> (full_q && data_q == $past(char_data)));
    // R3: overrun keeps the held character
    assert_ovr_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && full_q && !data_rd) |=> ($stable(data_q) && ovr_q));
    // R7: overrun falls only after an armed data read
    assert_ovr_clear_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_q) |-> $past(data_rd && arm_ovr));
    // R8: an unarmed data read leaves a pending overrun
    assert_late_ovr_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !arm_ovr && ovr_q) |=> ovr_q);
    // R11: set wins over clear on the same edge
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && arm_full && char_done) |=> (full_q && data_q == $past(char_data)));
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
    import rxf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int IDLE_SHORT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              long_frame,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_rdata,
    input  logic              idle_irq_en,
    input  logic              ovr_irq_en,
    output logic              err_irq
);
    logic              status_rd, data_rd;
    logic              full_q, ovr_q, idle_flag;
    logic              char_loaded, idle_clear;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] status_word;

    assign status_rd = rd_en && !rd_sel;
    assign data_rd   = rd_en && rd_sel;

    rxf_flag_ctrl #(.DATA_W(DATA_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_done   (char_done),
        .char_data   (char_data),
        .status_rd   (status_rd),
        .data_rd     (data_rd),
        .idle_flag   (idle_flag),
        .full_q      (full_q),
        .ovr_q       (ovr_q),
        .data_q      (data_q),
        .char_loaded (char_loaded),
        .idle_clear  (idle_clear)
    );

    rxf_idle_fsm #(.IDLE_SHORT(IDLE_SHORT)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_enable   (rx_enable),
        .long_frame  (long_frame),
        .bit_tick    (bit_tick),
        .rx_line     (rx_line),
        .char_loaded (char_loaded),
        .idle_clear  (idle_clear),
        .idle_flag   (idle_flag)
    );

    always_comb begin
        status_word          = '0;
        status_word[ST_FULL] = full_q;
        status_word[ST_IDLE] = idle_flag;
        status_word[ST_OVR]  = ovr_q;
        rd_rdata             = rd_sel ? data_q : status_word;
        err_irq              = (idle_flag && idle_irq_en) || (ovr_q && ovr_irq_en);
    end

    // R9: an interrupt needs an enabled flag behind it
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ((idle_irq_en && idle_flag) || (ovr_irq_en && ovr_q)));
endmodule

// File: tb/test_rx_status_flags.sv
module test_rx_status_flags;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_enable = 1'b1, long_frame = 1'b0, bit_tick = 1'b0, rx_line = 1'b1;
    logic char_done = 1'b0;
    logic [DW-1:0] char_data = '0;
    logic rd_en = 1'b0, rd_sel = 1'b0;
    logic [DW-1:0] rd_rdata;
    logic idle_irq_en = 1'b0, ovr_irq_en = 1'b0;
    logic err_irq;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] last_rd;

    // bench model
    logic m_full, m_ovr, a_full, a_idle, a_ovr;
    logic [DW-1:0] m_data;
    int m_ist, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_status_flags i_rx_status_flags (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .long_frame(long_frame),
        .bit_tick(bit_tick), .rx_line(rx_line), .char_done(char_done),
        .char_data(char_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_rdata(rd_rdata),
        .idle_irq_en(idle_irq_en), .ovr_irq_en(ovr_irq_en), .err_irq(err_irq)
    );

    function automatic logic [DW-1:0] exp_status();
        return {5'b0, m_ovr, (m_ist == 2), m_full};
    endfunction

    function automatic logic exp_irq();
        return ((m_ist == 2) && idle_irq_en) || (m_ovr && ovr_irq_en);
    endfunction

    function automatic void chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endfunction

    function automatic void model_reset();
        m_full = 0; m_ovr = 0; a_full = 0; a_idle = 0; a_ovr = 0;
        m_data = '0; m_ist = 0; m_cnt = 0;
    endfunction

    function automatic void model_step(logic ch, logic [DW-1:0] cd, logic tick,
                                       logic ln, logic rs, logic rdd);
        logic cf, co, ci, ld, os, idl;
        int tgt;
        cf = rdd && a_full; co = rdd && a_ovr; ci = rdd && a_idle;
        ld = ch && (!m_full || cf);
        os = ch && m_full && !cf;
        idl = (m_ist == 2);
        tgt = long_frame ? 11 : 10;
        if (m_ist == 2) begin
            if (ci) m_ist = 0;
        end else if (!rx_enable) begin
            m_ist = 0; m_cnt = 0;
        end else if (m_ist == 0) begin
            m_cnt = 0;
            if (ld) m_ist = 1;
        end else if (tick) begin
            if (!ln) m_cnt = 0;
            else if (m_cnt + 1 >= tgt) begin m_ist = 2; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
        if (rs) begin
            a_full = m_full; a_idle = idl; a_ovr = m_ovr;
        end else if (rdd) begin
            a_full = 0; a_idle = 0; a_ovr = 0;
        end
        if (ld) m_data = cd;
        m_full = ld || (m_full && !cf);
        m_ovr  = os || (m_ovr && !co);
    endfunction

    task automatic cyc(input logic ch, input logic [DW-1:0] cd, input logic tick,
                       input logic ln, input logic rs, input logic rdd);
        char_done = ch; char_data = cd; bit_tick = tick; rx_line = ln;
        rd_en = rs || rdd; rd_sel = rdd;
        #1;
        if (rdd) begin
            last_rd = rd_rdata;
            chk("R2 data read", rd_rdata, m_data);
        end
        if (rs) chk("R7 status read", rd_rdata, exp_status());
        @(posedge clk);
        model_step(ch, cd, tick, ln, rs, rdd);
        @(negedge clk);
        char_done = 0; bit_tick = 0; rd_en = 0; rd_sel = 0;
        #1;
        chk("R7 model status", rd_rdata, exp_status());
        chk("R9 model irq", err_irq, exp_irq());
    endtask

    task automatic ticks(input int n, input logic ln);
        for (int i = 0; i < n; i++) cyc(0, '0, 1, ln, 0, 0);
    endtask
    task automatic chr(input logic [DW-1:0] d); cyc(1, d, 0, 1, 0, 0); endtask
    task automatic srd(); cyc(0, '0, 0, 1, 1, 0); endtask
    task automatic drd(); cyc(0, '0, 0, 1, 0, 1); endtask

    function automatic logic [2:0] st();
        return rd_rdata[2:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 reset status", rd_rdata, 0);
        chk("R1 reset irq", err_irq, 0);

        // R5: no character yet, long high run must not set idle
        ticks(14, 1);
        chk("R5 idle before char", st(), 3'b000);
        // R2
        chk_load: begin
            chr(8'hA5);
            chk("R2 full after load", st(), 3'b001);
        end
        // R4 short window
        ticks(9, 1);
        chk("R4 idle after 9", st(), 3'b001);
        ticks(1, 1);
        chk("R4 idle after 10", st(), 3'b011);
        // R9
        idle_irq_en = 1; #1;
        chk("R9 idle irq", err_irq, 1);
        idle_irq_en = 0; #1;
        chk("R9 idle irq off", err_irq, 0);
        // R7: data read without status read
        drd();
        chk("R7 no clear without status", st(), 3'b011);
        srd(); drd();
        chk("R7 data value", last_rd, 8'hA5);
        chk("R7 cleared", st(), 3'b000);
        // R5: after clear, disarmed
        ticks(15, 1);
        chk("R5 rearm needs char", st(), 3'b000);
        // R6
        chr(8'h3C);
        ticks(5, 1); ticks(1, 0); ticks(9, 1);
        chk("R6 restart after low", st(), 3'b001);
        ticks(1, 1);
        chk("R6 idle after full run", st(), 3'b011);
        srd(); drd();
        // R4 long window
        long_frame = 1;
        chr(8'h11);
        ticks(10, 1);
        chk("R4 long after 10", st(), 3'b001);
        ticks(1, 1);
        chk("R4 long after 11", st(), 3'b011);
        srd(); drd();
        long_frame = 0;
        // R3 / R8
        chr(8'h01);
        srd();
        chr(8'h02);
        chk("R3 overrun set", st(), 3'b101);
        ovr_irq_en = 1; #1;
        chk("R9 ovr irq", err_irq, 1);
        ovr_irq_en = 0;
        drd();
        chk("R3 kept data", last_rd, 8'h01);
        chk("R8 overrun pending", st(), 3'b100);
        chr(8'h03);
        srd(); drd();
        chk("R8 next char", last_rd, 8'h03);
        chk("R8 all clear", st(), 3'b000);
        // R12
        chr(8'h04); chr(8'h05);
        srd(); srd(); drd();
        chk("R12 repeated status", st(), 3'b000);
        // R11
        chr(8'h06);
        srd();
        cyc(1, 8'h07, 0, 1, 0, 1);
        chk("R11 set wins", st()[2:0] & 3'b101, 3'b001);
        rd_sel = 1; #1;
        chk("R11 new data", rd_rdata, 8'h07);
        rd_sel = 0; #1;
        srd(); drd();
        // R10
        chr(8'h0A);
        srd(); drd();
        ticks(5, 1);
        rx_enable = 0; ticks(1, 1); rx_enable = 1;
        ticks(12, 1);
        chk("R10 disarmed", st(), 3'b000);
        chr(8'h0B);
        ticks(10, 1);
        chk("R10 rearmed", st(), 3'b011);
        srd(); drd();

        // random phase checked against the bench model
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic ch, tk, ln, rs, rdd;
            r = $urandom % 100;
            ch = ($urandom % 100) < 10;
            tk = ($urandom % 100) < 50;
            ln = ($urandom % 100) < 85;
            rs = r < 12;
            rdd = (r >= 12) && (r < 22);
            if (($urandom % 100) < 2) rx_enable = ~rx_enable;
            if (($urandom % 500) == 0) long_frame = ~long_frame;
            idle_irq_en = $urandom % 2;
            ovr_irq_en = $urandom % 2;
            cyc(ch, DW'($urandom), tk, ln, rs, rdd);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule